// File: doc/BRIEF.md
# Programmable-Rate Timestamp Clock

This block keeps a 64-bit time value that advances at a rate software can set. A free-running input pulse marks each elapsed nanosecond. An increment setting has two fields: a rate value and a period in ticks. Once every period ticks, the rate value is added to an internal accumulator that carries four extra fractional bits. The reported time is therefore the tick count times the rate value divided by sixteen times the period. A period field of zero acts as a period of one.

A capture strobe copies the current time into a pair of 32-bit output words, both on the same clock edge, so a reader never sees a half-updated value. When the increment setting is rewritten, the accumulator keeps everything it has gathered so far. Only the growth from then on follows the new rate, so the time never jumps. Any ticks of a period that was not yet complete are dropped, and the next period starts counting afresh.

Top module: `ts_clock`

## Requirements
- R1: After reset the increment setting, the time and both capture words are zero, so ticks do not advance the time until a setting is written.
- R2: The increment setting is a 32-bit word: bits 23:0 hold the rate value and bits 31:24 hold the period in ticks.
- R3: A period field of zero behaves exactly like a period of one.
- R4: Each time a full period of ticks completes, the rate value is added to a 68-bit accumulator; the time is the accumulator divided by 16 (its upper 64 bits).
- R5: The four fractional bits carry between periods, so a rate value of 1 with period 1 raises the time by one every 16 ticks.
- R6: A capture strobe loads time bits 31:0 into the low word and bits 63:32 into the high word on one edge; both words hold their value when there is no strobe.
- R7: Writing the increment setting keeps the accumulator unchanged, discards the partial period in progress, and applies the new rate from the next tick on.
- R8: A tick that arrives in the same cycle as a write is counted at the old rate and with the old period.
- R9: A capture in the same cycle as a tick returns the time from before that tick.
- R10: In cycles without a tick, the time and the period progress do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ns_tick | input | 1 | One pulse per elapsed nanosecond |
| cfg_we | input | 1 | Write strobe for the increment setting |
| cfg_wdata | input | 32 | New increment setting (period in 31:24, rate value in 23:0) |
| cap_req | input | 1 | Capture strobe |
| cap_lo | output | 32 | Captured time, bits 31:0 |
| cap_hi | output | 32 | Captured time, bits 63:32 |

## Verification
Two pairs of events can fall in the same cycle: a nanosecond tick with a rewrite of the setting, and a tick with a capture. The bench raises both strobes on the same edge. It expects the tick to be counted at the old rate and period, and the capture to return the time from before the tick. A sweep over small periods (zero included) and rate values checks each capture against a closed-form model, which adds the previous segments to floor(ticks/period) times the value. A long run at the largest rate value carries the time into the high word.

// File: rtl/ts_pkg.sv
package ts_pkg;
    localparam int TIME_W = 64;
    localparam int FRAC_W = 4;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } cap_pair_t;
endpackage

// File: rtl/ts_period_div.sv
module ts_period_div #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [PER_W-1:0] period_i,
    output logic             step_o
);
    localparam int CW = PER_W + 1;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CW-1:0] eff_per;
    logic [CW-1:0] cnt_inc;
    logic          wrap;

    always_comb begin
        st_d    = st_q;
        eff_per = (period_i == '0) ? CW'(1) : {1'b0, period_i};
        cnt_inc = {1'b0, st_q.cnt} + CW'(1);
        wrap    = tick_i && (cnt_inc >= eff_per);
        if (tick_i) begin
            st_d.cnt = wrap ? '0 : cnt_inc[PER_W-1:0];
        end
        if (clr_i) begin
            st_d.cnt = '0;
        end
        step_o = wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.cnt} < eff_per); // R3
    AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0)); // R7
    AST_IDLE_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(st_q.cnt)); // R10
endmodule

// File: rtl/ts_accum.sv
module ts_accum
    import ts_pkg::*;
#(
    parameter int VAL_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [VAL_W-1:0]  inc_i,
    output logic [TIME_W-1:0] time_o
);
    localparam int ACC_W = TIME_W + FRAC_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.acc = st_q.acc + ACC_W'(inc_i);
        end
        time_o = st_q.acc[ACC_W-1:FRAC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_STEP_ADDS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (st_q.acc == $past(st_q.acc) + ACC_W'($past(inc_i)))); // R4
    AST_NO_STEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(st_q.acc)); // R10
endmodule

// File: rtl/ts_capture.sv
module ts_capture
    import ts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [TIME_W-1:0] time_i,
    output logic [WORD_W-1:0] lo_o,
    output logic [WORD_W-1:0] hi_o
);
    cap_pair_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_i) begin
            st_d.lo = time_i[WORD_W-1:0];
            st_d.hi = time_i[TIME_W-1:WORD_W];
        end
        lo_o = st_q.lo;
        hi_o = st_q.hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CAPTURE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> ({hi_o, lo_o} == $past(time_i))); // R6
    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> ($stable(lo_o) && $stable(hi_o))); // R6
endmodule

// File: rtl/ts_clock.sv
module ts_clock
    import ts_pkg::*;
#(
    parameter int VAL_W = 24,
    parameter int PER_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ns_tick,
    input  logic                   cfg_we,
    input  logic [VAL_W+PER_W-1:0] cfg_wdata,
    input  logic                   cap_req,
    output logic [WORD_W-1:0]      cap_lo,
    output logic [WORD_W-1:0]      cap_hi
);
    localparam int CFG_W = VAL_W + PER_W;

    typedef struct packed {
        logic [PER_W-1:0] period;
        logic [VAL_W-1:0] value;
    } rate_cfg_t;

    rate_cfg_t         cfg_d, cfg_q;
    logic              step;
    logic [TIME_W-1:0] now;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d = rate_cfg_t'(cfg_wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    ts_period_div #(.PER_W(PER_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (ns_tick),
        .clr_i    (cfg_we),
        .period_i (cfg_q.period),
        .step_o   (step)
    );

    ts_accum #(.VAL_W(VAL_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .inc_i  (cfg_q.value),
        .time_o (now)
    );

    ts_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap_req),
        .time_i (now),
        .lo_o   (cap_lo),
        .hi_o   (cap_hi)
    );

    AST_WRITE_KEEPS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !ns_tick) |=> $stable(now)); // R7
endmodule

// File: tb/tb_ts_clock.sv
module tb_ts_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ns_tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cap_req = 1'b0;
    logic [31:0] cap_lo, cap_hi;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    logic [67:0] m_base = '0;
    int unsigned m_ticks = 0;
    logic [23:0] m_val = '0;
    logic [7:0]  m_per = '0;
    logic [63:0] exp_cap = '0;

    always #4 clk = ~clk;

    ts_clock dut (
        .clk(clk), .rst_n(rst_n), .ns_tick(ns_tick), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cap_req(cap_req), .cap_lo(cap_lo), .cap_hi(cap_hi)
    );

    function automatic logic [67:0] m_acc();
        int unsigned eff;
        eff = (m_per == 0) ? 1 : int'(m_per);
        return m_base + 68'(m_ticks / eff) * 68'(m_val);
    endfunction

    function automatic logic [63:0] m_time();
        logic [67:0] a;
        a = m_acc();
        return a[67:4];
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic cyc(input logic t, input logic w, input logic [31:0] wd, input logic c);
        @(negedge clk);
        ns_tick = t; cfg_we = w; cfg_wdata = wd; cap_req = c;
        if (c) exp_cap = m_time();
        @(posedge clk);
        if (t) m_ticks++;
        if (w) begin
            m_base  = m_acc();
            m_ticks = 0;
            m_val   = wd[23:0];
            m_per   = wd[31:24];
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, 1'b0);
    endtask

    task automatic wr(input logic [7:0] per, input logic [23:0] val);
        cyc(1'b0, 1'b1, {per, val}, 1'b0);
    endtask

    task automatic chk(input string req);
        @(negedge clk);
        ns_tick = 0; cfg_we = 0; cap_req = 0;
        n_chk++;
        if ({cap_hi, cap_lo} !== exp_cap) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, {cap_hi, cap_lo}, exp_cap);
        end
    endtask

    task automatic capchk(input string req);
        cyc(1'b0, 1'b0, '0, 1'b1);
        chk(req);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: got %0d cycles expected under 150000", cyc_cnt);
                report();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of the capture words
        exp_cap = '0;
        chk("R1 reset words");
        ticks(20);
        capchk("R1 zero setting");

        // R5: fraction carries, value 1 period 1
        wr(8'd1, 24'd1);
        ticks(15);
        capchk("R5 before 16");
        ticks(1);
        capchk("R5 at 16");

        // R3: period zero acts as one
        wr(8'd0, 24'd16);
        ticks(3);
        capchk("R3 period zero");

        // R7: partial period dropped on rewrite
        wr(8'd4, 24'd16);
        ticks(3);
        capchk("R7 partial");
        wr(8'd4, 24'd32);
        ticks(3);
        capchk("R7 restart");
        ticks(1);
        capchk("R7 new rate");

        // R10: idle cycles between ticks
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 1'b0, '0, 1'b0);
            cyc(1'b1, 1'b0, '0, 1'b0);
        end
        capchk("R10 gaps");

        // R2/R4 sweep over period and value fields
        for (int p = 0; p < 6; p++) begin
            for (int v = 0; v < 4; v++) begin
                logic [23:0] val;
                val = (v == 0) ? 24'd1 : (v == 1) ? 24'd7 : (v == 2) ? 24'd33 : 24'h80_0001;
                wr(8'(p), val);
                for (int k = 0; k < 3; k++) begin
                    ticks(k * 3 + 2);
                    capchk("R4 sweep");
                end
            end
        end
        capchk("R2 field layout");

        // R8: tick and write in one cycle
        wr(8'd3, 24'd48);
        ticks(2);
        cyc(1'b1, 1'b1, {8'd2, 24'd160}, 1'b0);
        capchk("R8 tick with write");
        ticks(2);
        capchk("R8 after write");

        // R9: capture and tick in one cycle
        wr(8'd1, 24'd160);
        cyc(1'b1, 1'b0, '0, 1'b1);
        chk("R9 capture with tick");
        capchk("R9 next capture");

        // R6: hold without strobe, then carry into high word
        ticks(5);
        chk("R6 hold");
        wr(8'd1, 24'hFF_FFFF);
        ticks(4200);
        capchk("R6 high word");

        report();
    end
endmodule